// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs an 8-bit accumulator value that came out of a plain binary addition of two packed-BCD bytes. It turns that value into a correct two-digit packed-BCD result and updates the carry flag. It works from three inputs: the raw accumulator, the carry flag left by the addition, and the digit-carry flag, which is the carry out of bit 3.

An operation starts when the issue strobe is high while the unit is idle. The instruction word presented on that cycle must equal the fixed adjust opcode 16'h0007. An accepted instruction then steps through four phases, one per clock:

- **decode**: checks the opcode match;
- **read**: samples the operand inputs;
- **process**: applies the digit corrections;
- **write**: loads the output registers.

Any other instruction word drops back to idle after decode and changes nothing. The digit-carry output always carries forward the digit-carry value read in, unchanged. No other status bit is produced.

The digit count is a parameter (default two digits, eight bits). Each digit is corrected by one slice, and the carry runs from the low slice to the high slice.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While reset is low, and after it is released, the accumulator, carry and digit-carry outputs are all 0.
- R2: If issue is high in the idle state with instrWord equal to 16'h0007, the outputs take their new values on the fourth rising edge after the accepting edge, and not before. The operand inputs are sampled on the second rising edge after the accepting edge.
- R3: An issue with any instrWord other than 16'h0007 leaves all three outputs unchanged.
- R4: When the low digit (bits 3:0) is above 9, or the digit-carry input is 1, the low digit gains 6, keeping 4 bits. Otherwise the low digit passes through unchanged.
- R5: The high digit (bits 7:4) first gains the carry out of the low-digit step. If that sum is above 9, or the carry input is 1, it gains a further 6, keeping 4 bits.
- R6: The carry output is 1 if the high-digit step overflows past 4 bits, or if the carry input was 1. Otherwise it is 0, so a carry input of 1 is never cleared.
- R7: The digit-carry output after an adjust equals the digit-carry input sampled by that operation.
- R8: An issue that arrives while an operation is in progress (decode, read, process or write phase) is ignored.
- R9: Input A5h with C=0 and DC=0 gives 05h with C=1 and DC=0. Input CEh with C=0 and DC=0 gives 34h with C=1.
- R10: For every binary sum of two valid packed-BCD bytes, with an add carry-in of 0 or 1, the result and carry equal the decimal sum modulo 100 and the decimal hundreds carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Strobe that presents an instruction word |
| instrWord | input | OPC_W (16) | Instruction word; only 16'h0007 triggers an adjust |
| accIn | input | 4*DIGITS (8) | Raw accumulator value from the binary add |
| carryIn | input | 1 | Carry flag left by the add |
| digitCarryIn | input | 1 | Digit-carry flag left by the add |
| accOut | output | 4*DIGITS (8) | Registered adjusted accumulator |
| carryOut | output | 1 | Registered carry flag |
| digitCarryOut | output | 1 | Registered digit-carry flag, passed through |

## Verification
The hardest case to reach is a low-digit correction whose carry pushes the high digit past 9 when the high digit alone was not above 9. Input 9Ah does this, and the full sweep of all BCD-pair sums with both carry-in values produces it many times, together with the digit-carry cases that leave the low digit at 0 to 3. A second hard case is a strobe that arrives during an operation. To cover it, the bench holds issue high across the busy phases and swaps the accumulator input after the read phase. A design that restarted would later show the swapped value.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_DECODE  = 3'd1,
    PH_READ    = 3'd2,
    PH_PROCESS = 3'd3,
    PH_WRITE   = 3'd4
  } adj_phase_t;

  // Strobes from control to datapath: one per working phase.
  typedef struct packed {
    logic capture;
    logic compute;
    logic commit;
  } adj_ctrl_t;

endpackage

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix (
  input  logic [3:0] digitIn,
  input  logic       carryIn,
  input  logic       forceFix,
  output logic [3:0] digitOut,
  output logic       carryOut
);
  logic [4:0] rawSum;
  logic [4:0] fixedSum;
  logic       needFix;

  always_comb begin
    rawSum   = {1'b0, digitIn} + {4'b0, carryIn};
    needFix  = forceFix || (rawSum > 5'd9);
    fixedSum = needFix ? (rawSum + 5'd6) : rawSum;
    digitOut = fixedSum[3:0];
    carryOut = fixedSum[4];
  end
endmodule

// File: rtl/bcd_adj_ctrl.sv
module bcd_adj_ctrl
  import bcd_adj_pkg::*;
#(
  parameter int               OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = 16'h0007
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [OPC_W-1:0] instrWord,
  output adj_ctrl_t        ctrl
);
  adj_phase_t phase;
  logic       hitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      hitReg <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (issue) begin
            phase  <= PH_DECODE;
            hitReg <= (instrWord == OPCODE);
          end
        end
        PH_DECODE:  phase <= hitReg ? PH_READ : PH_IDLE;
        PH_READ:    phase <= PH_PROCESS;
        PH_PROCESS: phase <= PH_WRITE;
        PH_WRITE:   phase <= PH_IDLE;
        default:    phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.capture = (phase == PH_READ);
    ctrl.compute = (phase == PH_PROCESS);
    ctrl.commit  = (phase == PH_WRITE);
  end

  // R8: a strobe during a busy phase never starts a new decode
  a_r8_busy_ignores_issue: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> (phase != PH_DECODE));

  // R2: at most one working strobe per cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.capture, ctrl.compute, ctrl.commit}));

  // R3: a missed opcode returns to idle without touching the datapath
  a_r3_miss_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DECODE && !hitReg) |=> !ctrl.capture);
endmodule

// File: rtl/bcd_adj_datapath.sv
module bcd_adj_datapath
  import bcd_adj_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  adj_ctrl_t             ctrl,
  input  logic [4*DIGITS-1:0]   accIn,
  input  logic                  carryIn,
  input  logic                  digitCarryIn,
  output logic [4*DIGITS-1:0]   accOut,
  output logic                  carryOut,
  output logic                  digitCarryOut
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0]    opAcc;
  logic            opC;
  logic            opDc;
  logic [W-1:0]    fixAcc;
  logic [DIGITS:0] chain;
  logic [W-1:0]    resAcc;
  logic            resC;
  logic            newC;

  // Operand registers: sampled in the read phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAcc <= '0;
      opC   <= 1'b0;
      opDc  <= 1'b0;
    end else if (ctrl.capture) begin
      opAcc <= accIn;
      opC   <= carryIn;
      opDc  <= digitCarryIn;
    end
  end

  assign chain[0] = 1'b0;

  // One slice per digit; the carry ripples from the low digit up
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic forceBit;
    if (i == 0) begin : g_low
      assign forceBit = opDc;
    end else if (i == DIGITS - 1) begin : g_high
      assign forceBit = opC;
    end else begin : g_mid
      assign forceBit = 1'b0;
    end
    bcd_digit_fix u_fix (
      .digitIn  (opAcc[4*i +: 4]),
      .carryIn  (chain[i]),
      .forceFix (forceBit),
      .digitOut (fixAcc[4*i +: 4]),
      .carryOut (chain[i+1])
    );
  end

  assign newC = opC | chain[DIGITS];

  // Result registers: loaded in the process phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resAcc <= '0;
      resC   <= 1'b0;
    end else if (ctrl.compute) begin
      resAcc <= fixAcc;
      resC   <= newC;
    end
  end

  // Output registers: loaded in the write phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut        <= '0;
      carryOut      <= 1'b0;
      digitCarryOut <= 1'b0;
    end else if (ctrl.commit) begin
      accOut        <= resAcc;
      carryOut      <= resC;
      digitCarryOut <= opDc;
    end
  end

  // R6: a carry already set on entry is never cleared
  a_r6_carry_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commit && opC) |=> carryOut);

  // R7: the digit-carry is carried forward unchanged
  a_r7_dc_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |=> (digitCarryOut == $past(opDc)));

  // R3: outputs move only on a write
  a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commit |=> ($stable(accOut) && $stable(carryOut) && $stable(digitCarryOut)));
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int               DIGITS = 2,
  parameter int               OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = 16'h0007
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issue,
  input  logic [OPC_W-1:0]    instrWord,
  input  logic [4*DIGITS-1:0] accIn,
  input  logic                carryIn,
  input  logic                digitCarryIn,
  output logic [4*DIGITS-1:0] accOut,
  output logic                carryOut,
  output logic                digitCarryOut
);
  adj_ctrl_t ctrl;

  bcd_adj_ctrl #(.OPC_W(OPC_W), .OPCODE(OPCODE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issue     (issue),
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  bcd_adj_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .accIn         (accIn),
    .carryIn       (carryIn),
    .digitCarryIn  (digitCarryIn),
    .accOut        (accOut),
    .carryOut      (carryOut),
    .digitCarryOut (digitCarryOut)
  );
endmodule

// File: tb/bcd_adjust_unit_bench.sv
module bcd_adjust_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instrWord = '0;
  logic [7:0]  accIn = '0;
  logic        carryIn = 1'b0;
  logic        digitCarryIn = 1'b0;
  logic [7:0]  accOut;
  logic        carryOut;
  logic        digitCarryOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_adjust_unit u_bcd_adjust_unit (
    .clk(clk), .rstN(rstN), .issue(issue), .instrWord(instrWord),
    .accIn(accIn), .carryIn(carryIn), .digitCarryIn(digitCarryIn),
    .accOut(accOut), .carryOut(carryOut), .digitCarryOut(digitCarryOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Decimal-adjust reference in integer arithmetic
  function automatic int refAdjust(input int a, input int c, input int dc);
    int lo, hi, lc, nc;
    lo = a % 16;
    hi = a / 16;
    if (lo > 9 || dc != 0) lo = lo + 6;
    lc = (lo >= 16) ? 1 : 0;
    lo = lo % 16;
    hi = hi + lc;
    if (hi > 9 || c != 0) hi = hi + 6;
    nc = (c != 0 || hi >= 16) ? 1 : 0;
    hi = hi % 16;
    return (nc << 8) | (hi << 4) | lo;
  endfunction

  // Cycle model: step counter after acceptance, expected outputs
  int mStep = 0;
  int mHit = 0;
  int mAcc = 0, mC = 0, mDc = 0;
  int mRes = 0;
  int expAcc = 0, expC = 0, expDc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mStep = 0; expAcc = 0; expC = 0; expDc = 0;
    end else begin
      if (mStep == 0) begin
        if (issue) begin
          mStep = 1;
          mHit = (instrWord == 16'h0007) ? 1 : 0;
        end
      end else if (mStep == 1) begin
        mStep = mHit ? 2 : 0;
      end else if (mStep == 2) begin
        mAcc = accIn; mC = carryIn; mDc = digitCarryIn;
        mStep = 3;
      end else if (mStep == 3) begin
        mRes = refAdjust(mAcc, mC, mDc);
        mStep = 4;
      end else begin
        expAcc = mRes & 255;
        expC = mRes >> 8;
        expDc = mDc;
        mStep = 0;
      end
    end
  end

  // Every-clock comparison against the model (R2 timing, R4..R7 values)
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 clk acc", accOut, expAcc);
      chk("R6 clk carry", carryOut, expC);
      chk("R7 clk dc", digitCarryOut, expDc);
    end
  end

  task automatic doOp(input logic [15:0] w, input logic [7:0] a,
                      input logic c, input logic dc);
    instrWord = w; accIn = a; carryIn = c; digitCarryIn = dc; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    int da, db, cin, sum, dsum;
    logic [7:0] ba, bb;
    accIn = 8'hFF; carryIn = 1'b1; digitCarryIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset acc", accOut, 0);
    chk("R1 reset carry", carryOut, 0);
    chk("R1 reset dc", digitCarryOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release acc", accOut, 0);

    doOp(16'h0007, 8'hA5, 1'b0, 1'b0);
    chk("R9 A5 acc", accOut, 8'h05);
    chk("R9 A5 carry", carryOut, 1);
    chk("R9 A5 dc", digitCarryOut, 0);
    doOp(16'h0007, 8'hCE, 1'b0, 1'b0);
    chk("R9 CE acc", accOut, 8'h34);
    chk("R9 CE carry", carryOut, 1);

    doOp(16'h0007, 8'h0C, 1'b0, 1'b0);
    chk("R4 low fix carries up", accOut, 8'h12);
    chk("R4 carry clear", carryOut, 0);
    doOp(16'h0007, 8'h15, 1'b0, 1'b1);
    chk("R4 dc forces fix", accOut, 8'h1B);
    chk("R7 dc passed", digitCarryOut, 1);
    doOp(16'h0007, 8'h9A, 1'b0, 1'b0);
    chk("R5 low carry pushes high", accOut, 8'h00);
    chk("R6 high overflow sets carry", carryOut, 1);
    doOp(16'h0007, 8'h12, 1'b1, 1'b0);
    chk("R5 carry forces high fix", accOut, 8'h72);
    chk("R6 carry sticky", carryOut, 1);
    doOp(16'h0007, 8'h45, 1'b0, 1'b0);
    chk("R6 no spurious carry", {carryOut, accOut}, 9'h045);

    doOp(16'h0107, 8'h99, 1'b1, 1'b1);
    chk("R3 other opcode acc", accOut, 8'h45);
    chk("R3 other opcode flags", {carryOut, digitCarryOut}, 0);

    // R2: outputs change on the fourth edge after acceptance, not earlier
    instrWord = 16'h0007; accIn = 8'h05; carryIn = 1'b0; digitCarryIn = 1'b1;
    issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 not yet", accOut, 8'h45);
    @(negedge clk);
    chk("R2 on time", accOut, 8'h0B);

    // R8: strobe held through busy phases, input swapped after read
    instrWord = 16'h0007; accIn = 8'h0C; carryIn = 1'b0; digitCarryIn = 1'b0;
    issue = 1'b1;
    repeat (3) @(negedge clk);
    accIn = 8'h77;
    @(negedge clk);
    issue = 1'b0;
    @(negedge clk);
    chk("R8 first result", accOut, 8'h12);
    repeat (6) @(negedge clk);
    chk("R8 no restart", accOut, 8'h12);

    // R10: every BCD pair sum with and without add carry-in
    for (int i = 0; i < 100; i++) begin
      for (int j = 0; j < 100; j++) begin
        for (int k = 0; k < 2; k++) begin
          da = i; db = j; cin = k;
          ba = 8'((da / 10) * 16 + da % 10);
          bb = 8'((db / 10) * 16 + db % 10);
          sum = int'(ba) + int'(bb) + cin;
          dsum = da + db + cin;
          doOp(16'h0007, 8'(sum & 255), (sum > 255),
               ((int'(ba) % 16 + int'(bb) % 16 + cin) > 15));
          chk("R10 decimal sum", {carryOut, accOut},
              ((dsum >= 100) ? 256 : 0) + ((dsum % 100) / 10) * 16 + (dsum % 10));
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule